// File: doc/BRIEF.md
# CPU-to-ISA I/O Window Bridge

This block sits between a big-endian CPU bus and a little-endian ISA I/O port bus. A CPU access that falls inside an 8 MB I/O window at 0x80000000 is turned into an I/O port read or write of byte, halfword or word size. The port number is built from the window offset in one of two ways. The `map_sparse` input selects the way. In contiguous mode the port is the low 16 bits of the offset. In sparse mode the low 5 offset bits are kept, and offset bits 12 and up are moved down to start at bit 5.

Multi-byte data is byte-swapped on the way to the I/O side and again on the way back. Byte data passes through unchanged. A separate 4-byte location serves interrupt acknowledge. A read of its first byte pulses a strobe toward an external interrupt controller and returns that controller's vector, swapped by access size like any other read. Any access that hits neither region is not forwarded. It completes at once with zero data and an error flag.

The CPU holds `cpu_req` and its fields steady until `cpu_done` pulses. The I/O side sees `io_valid` with stable fields until it answers with `io_ready`.

Top module: `isa_io_bridge`

## Requirements
- R1: With `map_sparse`=0, a window access drives `io_port` = offset[15:0], where offset = `cpu_addr` - 0x80000000 and the window is 0x80000000 to 0x807FFFFF.
- R2: With `map_sparse`=1, a window access drives `io_port` = {offset[22:12], offset[4:0]}, which equals (offset AND 0x1F) OR ((offset AND 0x7FF000) >> 7).
- R3: Write data to the I/O side depends on size. For byte (size 2'b00) it is {24'h0, wdata[7:0]}. For halfword (2'b01) the two low bytes are exchanged. For word (2'b10) all four bytes are reversed.
- R4: Read data from the I/O side is returned to the CPU with the same size-dependent swap as in R3.
- R5: `io_valid` stays high with `io_port`, `io_wdata`, `io_size` and `io_we` unchanged until `io_ready`. These fields are captured when the access is accepted, so a later change of `map_sparse` does not alter them. `cpu_done` rises in the cycle after `io_ready`.
- R6: A read at exactly 0xBFFFFFF0 raises `iack_strobe` for exactly one cycle. It returns `iack_vector` zero-extended and then swapped by size, as in R3: byte gives 0x000000VV, halfword 0x0000VV00, word 0xVV000000.
- R7: The other bytes of the region 0xBFFFFFF0 to 0xBFFFFFF3 read 0. Any write to the region is ignored: no strobe, no I/O access and no error.
- R8: An access outside both regions, or any access with size 2'b11, is not forwarded. It completes with `cpu_err`=1 and `cpu_rdata`=0.
- R9: After reset, `io_valid`, `iack_strobe`, `cpu_done` and `cpu_err` are 0.
- R10: `cpu_done` is a one-cycle pulse per accepted access, and `cpu_rdata` and `cpu_err` are 0 whenever `cpu_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_sparse | input | 1 | 0 contiguous, 1 sparse port mapping |
| cpu_req | input | 1 | CPU access request, held until done |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_size | input | 2 | 00 byte, 01 halfword, 10 word |
| cpu_addr | input | 32 | CPU byte address |
| cpu_wdata | input | 32 | CPU write data (big-endian lanes) |
| cpu_done | output | 1 | Access complete pulse |
| cpu_err | output | 1 | Access hit no region or used a bad size |
| cpu_rdata | output | 32 | Read data, valid with done |
| io_valid | output | 1 | I/O access pending |
| io_we | output | 1 | I/O write |
| io_size | output | 2 | I/O access size |
| io_port | output | 16 | ISA port number |
| io_wdata | output | 32 | Swapped write data |
| io_ready | input | 1 | I/O side completes the access |
| io_rdata | input | 32 | I/O read data (little-endian lanes) |
| iack_strobe | output | 1 | Interrupt acknowledge pulse |
| iack_vector | input | 8 | Vector from the interrupt controller |

## Verification
The map-type input and an in-flight I/O access can change in the same cycle: software may flip the mapping mode while the I/O side is still stalling a forwarded access. The bench starts a contiguous-mode access, holds `io_ready` low for several cycles, and toggles `map_sparse` in each of them. It checks every cycle that `io_port` keeps the contiguous value and that `cpu_done` stays low. Done must then come exactly one cycle after the ready.

// File: rtl/isa_io_bridge.sv
module isa_io_bridge #(
  parameter logic [31:0] WIN_BASE  = 32'h8000_0000,
  parameter logic [31:0] IACK_ADDR = 32'hBFFF_FFF0,
  parameter int          VEC_W     = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        map_sparse,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [1:0]  cpu_size,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic        cpu_done,
  output logic        cpu_err,
  output logic [31:0] cpu_rdata,
  output logic        io_valid,
  output logic        io_we,
  output logic [1:0]  io_size,
  output logic [15:0] io_port,
  output logic [31:0] io_wdata,
  input  logic        io_ready,
  input  logic [31:0] io_rdata,
  output logic        iack_strobe,
  input  logic [VEC_W-1:0] iack_vector
);
  localparam int WIN_BITS = 23;

  typedef enum logic [1:0] {S_IDLE, S_IO, S_ACK, S_RESP} state_t;
  state_t st;

  logic [31:0] rdata_q;
  logic        err_q;

  function automatic logic [31:0] lane_swap(input logic [1:0] sz, input logic [31:0] d);
    case (sz)
      2'b00:   return {24'h0, d[7:0]};
      2'b01:   return {16'h0, d[7:0], d[15:8]};
      default: return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endcase
  endfunction

  wire [WIN_BITS-1:0] off = cpu_addr[WIN_BITS-1:0];
  wire in_win   = cpu_addr[31:WIN_BITS] == WIN_BASE[31:WIN_BITS];
  wire in_iack  = cpu_addr[31:2] == IACK_ADDR[31:2];
  wire iack_hit = cpu_addr == IACK_ADDR;
  wire size_ok  = cpu_size != 2'b11;
  wire [15:0] port_map = map_sparse ? {off[22:12], off[4:0]} : off[15:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      rdata_q <= '0;
      err_q <= 1'b0;
      io_we <= 1'b0;
      io_size <= 2'b00;
      io_port <= '0;
      io_wdata <= '0;
    end else begin
      case (st)
        S_IDLE: if (cpu_req) begin
          io_size <= cpu_size;
          rdata_q <= '0;
          err_q   <= 1'b0;
          if (size_ok && in_win) begin
            io_we    <= cpu_we;
            io_port  <= port_map;
            io_wdata <= cpu_we ? lane_swap(cpu_size, cpu_wdata) : '0;
            st <= S_IO;
          end else if (size_ok && in_iack) begin
            st <= (!cpu_we && iack_hit) ? S_ACK : S_RESP;
          end else begin
            err_q <= 1'b1;
            st <= S_RESP;
          end
        end
        S_IO: if (io_ready) begin
          rdata_q <= io_we ? '0 : lane_swap(io_size, io_rdata);
          st <= S_RESP;
        end
        S_ACK: begin
          rdata_q <= lane_swap(io_size, {{(32-VEC_W){1'b0}}, iack_vector});
          st <= S_RESP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign io_valid    = st == S_IO;
  assign iack_strobe = st == S_ACK;
  assign cpu_done    = st == S_RESP;
  assign cpu_rdata   = cpu_done ? rdata_q : '0;
  assign cpu_err     = cpu_done & err_q;

  p_io_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    io_valid && !io_ready |=> io_valid && $stable(io_port) && $stable(io_wdata) && $stable(io_size));
  p_io_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    io_valid && io_ready |=> cpu_done);
  p_strobe_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    iack_strobe |=> !iack_strobe && cpu_done);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);
  p_err_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_err |-> cpu_rdata == 32'h0 && !io_valid);
  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({io_valid, iack_strobe, cpu_done}) <= 1);
endmodule

// File: tb/isa_io_bridge_tb.sv
module isa_io_bridge_tb_top;
  logic clk = 0, rst_n = 0;
  logic map_sparse = 0, cpu_req = 0, cpu_we = 0;
  logic [1:0] cpu_size = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0, io_rdata = 0;
  logic io_ready = 0;
  logic [7:0] iack_vector = 8'h2A;
  logic cpu_done, cpu_err, io_valid, io_we, iack_strobe;
  logic [1:0] io_size;
  logic [15:0] io_port;
  logic [31:0] cpu_rdata, io_wdata;

  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  isa_io_bridge dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  logic [31:0] r_data, r_iowd;
  logic [15:0] r_port;
  logic r_err, r_io;
  int r_strobes;

  task automatic access(input logic we, input logic [31:0] addr, input logic [1:0] sz,
                        input logic [31:0] wd, input logic [31:0] resp, input int stall,
                        input logic flip_map);
    int wait_n;
    logic [15:0] first_port;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = addr; cpu_size = sz; cpu_wdata = wd;
    r_io = 0; r_strobes = 0; r_data = 'x; r_err = 'x; wait_n = stall;
    first_port = '0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (iack_strobe) r_strobes++;
      if (cpu_done) begin
        r_data = cpu_rdata; r_err = cpu_err;
        break;
      end
      if (io_valid) begin
        if (!r_io) begin
          r_io = 1; r_port = io_port; r_iowd = io_wdata; first_port = io_port;
        end else begin
          chk("R5 port held during stall", {16'h0, io_port}, {16'h0, first_port});
        end
        if (wait_n == 0) begin
          io_ready = 1; io_rdata = resp;
        end else begin
          wait_n--;
          if (flip_map) map_sparse = ~map_sparse;
        end
      end
    end
    cpu_req = 0; io_ready = 0;
    @(negedge clk);
    chk("R10 done is one pulse", {31'h0, cpu_done}, 32'h0);
    chk("R10 rdata zero without done", cpu_rdata, 32'h0);
  endtask

  task automatic t_reset;
    chk("R9 reset io_valid", {31'h0, io_valid}, 0);
    chk("R9 reset done", {31'h0, cpu_done}, 0);
    chk("R9 reset strobe", {31'h0, iack_strobe}, 0);
    chk("R9 reset err", {31'h0, cpu_err}, 0);
  endtask

  task automatic t_contig;
    map_sparse = 0;
    access(0, 32'h8000_03F8, 2'b00, 0, 32'h1234_56A5, 0, 0);
    chk("R1 contig port", {16'h0, r_port}, 32'h03F8);
    chk("R4 byte read", r_data, 32'h0000_00A5);
    access(0, 32'h8012_3456, 2'b00, 0, 0, 0, 0);
    chk("R1 contig high offset", {16'h0, r_port}, 32'h3456);
  endtask

  task automatic t_sparse;
    map_sparse = 1;
    access(0, 32'h8012_3456, 2'b00, 0, 0, 0, 0);
    chk("R2 sparse port", {16'h0, r_port}, 32'h2476);
    access(0, 32'h807F_F01F, 2'b00, 0, 0, 0, 0);
    chk("R2 sparse top port", {16'h0, r_port}, 32'hFFFF);
    map_sparse = 0;
  endtask

  task automatic t_swap;
    access(1, 32'h8000_0060, 2'b00, 32'hAABB_CCDD, 0, 0, 0);
    chk("R3 byte write", r_iowd, 32'h0000_00DD);
    access(1, 32'h8000_0060, 2'b01, 32'h0000_1234, 0, 0, 0);
    chk("R3 half write", r_iowd, 32'h0000_3412);
    access(1, 32'h8000_0060, 2'b10, 32'h1122_3344, 0, 0, 0);
    chk("R3 word write", r_iowd, 32'h4433_2211);
    chk("R3 write reads zero", r_data, 32'h0);
    access(0, 32'h8000_0060, 2'b01, 0, 32'h0000_ABCD, 0, 0);
    chk("R4 half read", r_data, 32'h0000_CDAB);
    access(0, 32'h8000_0060, 2'b10, 0, 32'hDEAD_BEEF, 0, 0);
    chk("R4 word read", r_data, 32'hEFBE_ADDE);
  endtask

  task automatic t_stall_flip;
    map_sparse = 0;
    access(0, 32'h8012_3456, 2'b10, 0, 32'h0102_0304, 4, 1);
    chk("R5 port from accept-time mode", {16'h0, r_port}, 32'h3456);
    chk("R5 data after stall", r_data, 32'h0403_0201);
    map_sparse = 0;
  endtask

  task automatic t_iack;
    iack_vector = 8'h2A;
    access(0, 32'hBFFF_FFF0, 2'b00, 0, 0, 0, 0);
    chk("R6 byte vector", r_data, 32'h0000_002A);
    chk("R6 one strobe", r_strobes, 1);
    chk("R6 not forwarded", {31'h0, r_io}, 0);
    access(0, 32'hBFFF_FFF0, 2'b01, 0, 0, 0, 0);
    chk("R6 half vector", r_data, 32'h0000_2A00);
    access(0, 32'hBFFF_FFF0, 2'b10, 0, 0, 0, 0);
    chk("R6 word vector", r_data, 32'h2A00_0000);
    chk("R6 one strobe word", r_strobes, 1);
  endtask

  task automatic t_iack_other;
    access(0, 32'hBFFF_FFF2, 2'b00, 0, 0, 0, 0);
    chk("R7 other byte reads zero", r_data, 32'h0);
    chk("R7 other byte no strobe", r_strobes, 0);
    chk("R7 other byte no err", {31'h0, r_err}, 0);
    access(1, 32'hBFFF_FFF0, 2'b10, 32'hFFFF_FFFF, 0, 0, 0);
    chk("R7 write no strobe", r_strobes, 0);
    chk("R7 write no io", {31'h0, r_io}, 0);
    chk("R7 write no err", {31'h0, r_err}, 0);
  endtask

  task automatic t_error;
    access(0, 32'h0000_1000, 2'b10, 0, 32'hFFFF_FFFF, 0, 0);
    chk("R8 outside err", {31'h0, r_err}, 1);
    chk("R8 outside zero", r_data, 0);
    chk("R8 outside no io", {31'h0, r_io}, 0);
    access(0, 32'h8080_0000, 2'b00, 0, 0, 0, 0);
    chk("R8 just past window err", {31'h0, r_err}, 1);
    access(1, 32'h8000_0010, 2'b11, 0, 0, 0, 0);
    chk("R8 bad size err", {31'h0, r_err}, 1);
    chk("R8 bad size no io", {31'h0, r_io}, 0);
  endtask

  initial begin
    #(200000 * 10);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_contig();
    t_sparse();
    t_swap();
    t_stall_flip();
    t_iack();
    t_iack_other();
    t_error();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule